// File: doc/BRIEF.md
# Third-Order Sinc Bitstream Decimator

This block converts the one-bit output of a delta-sigma modulator into multi-bit samples. It runs three cascaded accumulators at the bit rate and three differencing stages at the decimated rate. Together they apply the response ((1 − z^-M)/(1 − z^-1))^3, where M is the oversampling ratio. One result word is produced for every M accepted bits. Its first response null therefore lies at the word rate: a 10 MHz bit stream at M = 32 yields words at 312.5 kHz.

The system clock runs faster than the bit stream. A clock enable marks each cycle that carries a new bit. The oversampling ratio is chosen at run time as a power of two from 16 to 256. Changing it restarts the filter from an empty history. Words are scaled so that a stream of all ones reads 32768 at every ratio. Each word can be delivered as an offset-binary code or as a two's-complement value centred on a 50 % ones density. A settled flag tells the consumer when the words reflect only data gathered since the last restart, which takes three word periods.

Top module: `sinc3_decimator`

## Requirements
- R1: While and immediately after reset, `valid_o` and `settled_o` are 0 and `data_o` is 0; the ratio after reset is 256.
- R2: A bit is accepted only in a cycle with `bit_en` high (value 1 weighs +1, value 0 weighs 0). After every M accepted bits since the last restart, one word equals the sum of the latest 3M−2 accepted bits weighted by the coefficients of a three-fold convolution of length-M boxcars, with bits before the restart counted as 0.
- R3: `osr_log2` selects M = 2^`osr_log2`; values below 4 act as 4 (M = 16) and values above 8 act as 8 (M = 256).
- R4: In offset format (`fmt_signed` = 0) the word is floor(raw · 2^15 / M^3), where raw is the R2 sum, so a full run of ones gives 32768 and a 50 % stream gives 16384.
- R5: With `fmt_signed` = 1 the word is the R4 value minus 16384 in 16-bit two's complement; the format is taken in the cycle whose accepted bit completes the word.
- R6: `valid_o` is high for exactly one cycle, in the cycle after the clock edge that accepted the completing bit, and low in every other cycle.
- R7: A change of the effective ratio (after the clamp of R3) clears all filter state and the bit counter, discards the bit of that cycle, and is followed by a cycle with `valid_o` low; a change of `osr_log2` that keeps the effective ratio does nothing.
- R8: `settled_o` is 0 after reset or restart, rises together with the `valid_o` of the third word after it, and stays 1 until the next reset or restart.
- R9: Words stay correct over arbitrarily long streams; the accumulators wrap modulo 2^25 and the differencing stages undo the wrap.
- R10: `data_o` holds its last word in every cycle without `valid_o`, including across a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks a cycle that carries a modulator bit |
| bit_in | input | 1 | Modulator bit |
| osr_log2 | input | 4 | Base-2 logarithm of the oversampling ratio, clamped to 4..8 |
| fmt_signed | input | 1 | 0: offset-binary word, 1: two's-complement word |
| data_o | output | 16 | Decimated result word |
| valid_o | output | 1 | One-cycle strobe for a new word |
| settled_o | output | 1 | High once three words have passed since reset or restart |

## Verification
The assertions take several properties of the stimulus for granted. `bit_in` and `fmt_signed` are defined in every enabled cycle. `osr_log2` is stable around each clock edge. Words are spaced by at least sixteen enabled cycles. The bench keeps to these by changing every input only at the falling edge. Its random phase draws the ratio code over its full range of sixteen values, the enable density from 30 to 100 %, and the ones density from 0 to 100 %. It also includes directed runs of all ones, all zeros, alternating bits, and ratio codes that lie outside the legal range or alias to the current ratio.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_SIGNED = 1'b1
    } word_fmt_e;

    localparam int unsigned NUM_STAGES = 3;

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
    parameter int unsigned SEL_W    = 4,
    parameter int unsigned MIN_LOG2 = 4,
    parameter int unsigned MAX_LOG2 = 8,
    localparam int unsigned L_W     = $clog2(MAX_LOG2 + 1),
    localparam int unsigned CNT_W   = MAX_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] osr_sel,
    input  logic             bit_en,
    output logic             restart,
    output logic             step,
    output logic             dump,
    output logic [L_W-1:0]   lg_o,
    output logic             settled_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [L_W-1:0]   lg;
        logic [1:0]       words;
        logic             settled;
    } ctrl_t;

    ctrl_t         s_d, s_q;
    logic [L_W-1:0] eff_lg;
    logic [CNT_W:0] lim;
    logic           last;

    always_comb begin
        if (int'(osr_sel) < int'(MIN_LOG2))
            eff_lg = L_W'(MIN_LOG2);
        else if (int'(osr_sel) > int'(MAX_LOG2))
            eff_lg = L_W'(MAX_LOG2);
        else
            eff_lg = L_W'(osr_sel);

        lim     = (CNT_W+1)'(1) << s_q.lg;
        last    = ({1'b0, s_q.cnt} == (lim - (CNT_W+1)'(1)));
        restart = (eff_lg != s_q.lg);
        step    = bit_en && !restart;
        dump    = step && last;

        s_d = s_q;
        if (restart) begin
            s_d.cnt     = '0;
            s_d.lg      = eff_lg;
            s_d.words   = '0;
            s_d.settled = 1'b0;
        end else if (step) begin
            s_d.cnt = last ? '0 : s_q.cnt + CNT_W'(1);
            if (last) begin
                s_d.words   = (s_q.words == 2'd3) ? 2'd3 : s_q.words + 2'd1;
                s_d.settled = s_q.settled || (s_q.words == 2'd2);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt     <= '0;
            s_q.lg      <= L_W'(MAX_LOG2);
            s_q.words   <= '0;
            s_q.settled <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lg_o      = s_q.lg;
    assign settled_o = s_q.settled;

    // R3: the held ratio exponent never leaves the legal window
    a_r3_lg_window: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(s_q.lg) >= int'(MIN_LOG2)) && (int'(s_q.lg) <= int'(MAX_LOG2)));

    // R2: the bit counter stays below the current ratio
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, s_q.cnt} < lim));

    // R8: the settled flag drops only through a restart
    a_r8_settle_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.settled) |-> $past(restart));

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int unsigned ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_in,
    output logic [ACC_W-1:0] sum_next
);
    import sinc3_pkg::*;

    typedef struct packed {
        logic [NUM_STAGES-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t                           s_d, s_q;
    logic [NUM_STAGES-1:0][ACC_W-1:0] upd;

    always_comb begin
        upd[0] = s_q.acc[0] + ACC_W'(bit_in);
        for (int k = 1; k < int'(NUM_STAGES); k++) begin
            upd[k] = s_q.acc[k] + upd[k-1];
        end

        s_d = s_q;
        if (clear)
            s_d.acc = '0;
        else if (step)
            s_d.acc = upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sum_next = upd[NUM_STAGES-1];

    // R7: a clear empties every accumulator on the next edge
    a_r7_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q.acc == '0));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int unsigned ACC_W = 25,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned L_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             dump,
    input  logic [ACC_W-1:0] sample,
    input  logic [L_W-1:0]   lg,
    input  logic             fmt_signed,
    output logic [OUT_W-1:0] data_o,
    output logic             valid_o
);
    import sinc3_pkg::*;

    localparam int unsigned WIDE_W = ACC_W + OUT_W;
    localparam logic [OUT_W-1:0] HALF = OUT_W'(1) << (OUT_W - 2);

    typedef struct packed {
        logic [NUM_STAGES-1:0][ACC_W-1:0] dly;
        logic [OUT_W-1:0]                 data;
        logic                             valid;
    } comb_t;

    comb_t                          s_d, s_q;
    logic [NUM_STAGES:0][ACC_W-1:0] stg;
    logic [ACC_W-1:0]               raw;
    logic [WIDE_W-1:0]              wide;
    logic [OUT_W-1:0]               off_word;
    word_fmt_e                      fmt;

    always_comb begin
        stg[0] = sample;
        for (int k = 0; k < int'(NUM_STAGES); k++) begin
            stg[k+1] = stg[k] - s_q.dly[k];
        end
        raw      = stg[NUM_STAGES];
        wide     = ({{OUT_W{1'b0}}, raw} << (OUT_W - 1)) >> (3 * lg);
        off_word = OUT_W'(wide);
        fmt      = word_fmt_e'(fmt_signed);

        s_d       = s_q;
        s_d.valid = 1'b0;
        if (clear) begin
            s_d.dly = '0;
        end else if (dump) begin
            for (int k = 0; k < int'(NUM_STAGES); k++) begin
                s_d.dly[k] = stg[k];
            end
            s_d.data  = (fmt == FMT_SIGNED) ? off_word - HALF : off_word;
            s_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data_o  = s_q.data;
    assign valid_o = s_q.valid;

    // R4: a completed word never exceeds M^3 before scaling
    a_r4_raw_range: assert property (@(posedge clk) disable iff (!rst_n)
        dump |-> ({1'b0, raw} <= ((ACC_W+1)'(1) << (3 * lg))));

    // R6: two words can never arrive on neighbouring cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> !s_q.valid);

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
    parameter int unsigned SEL_W    = 4,
    parameter int unsigned MIN_LOG2 = 4,
    parameter int unsigned MAX_LOG2 = 8,
    parameter int unsigned OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic [SEL_W-1:0] osr_log2,
    input  logic             fmt_signed,
    output logic [OUT_W-1:0] data_o,
    output logic             valid_o,
    output logic             settled_o
);
    import sinc3_pkg::*;

    localparam int unsigned ACC_W = NUM_STAGES * MAX_LOG2 + 1;
    localparam int unsigned L_W   = $clog2(MAX_LOG2 + 1);

    logic             restart;
    logic             step;
    logic             dump;
    logic [L_W-1:0]   lg;
    logic [ACC_W-1:0] sum_next;

    sinc3_ctrl #(
        .SEL_W    (SEL_W),
        .MIN_LOG2 (MIN_LOG2),
        .MAX_LOG2 (MAX_LOG2)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .osr_sel   (osr_log2),
        .bit_en    (bit_en),
        .restart   (restart),
        .step      (step),
        .dump      (dump),
        .lg_o      (lg),
        .settled_o (settled_o)
    );

    sinc3_integ #(
        .ACC_W (ACC_W)
    ) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .step     (step),
        .bit_in   (bit_in),
        .sum_next (sum_next)
    );

    sinc3_comb #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .L_W   (L_W)
    ) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .dump       (dump),
        .sample     (sum_next),
        .lg         (lg),
        .fmt_signed (fmt_signed),
        .data_o     (data_o),
        .valid_o    (valid_o)
    );

    // R6: a word only follows an edge that accepted a bit
    a_r6_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bit_en));

    // R7: no word in the cycle after a restart
    a_r7_quiet_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> !valid_o);

    // R8: settled rises only together with a word
    a_r8_rise_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> valid_o);

    // R10: output data only moves with a word
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

endmodule

// File: tb/sim_sinc3_decimator.sv
module sim_sinc3_decimator;

    localparam int CLK_PERIOD = 10;
    localparam int HIST       = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [3:0]  osr_log2 = 4'd8;
    logic        fmt_signed = 1'b0;
    logic [15:0] data_o;
    logic        valid_o;
    logic        settled_o;

    int vectors = 0;
    int fails = 0;

    int     m_lg = 8;
    int     m_n = 0;
    int     m_words = 0;
    bit     hist [HIST];
    longint coef [768];
    bit     exp_valid = 1'b0;
    bit     exp_settled = 1'b0;
    logic [15:0] exp_data = 16'd0;
    bit     after_restart = 1'b0;
    bit     alt_bit = 1'b0;
    string  cur_tag = "R2";

    sinc3_decimator u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .osr_log2   (osr_log2),
        .fmt_signed (fmt_signed),
        .data_o     (data_o),
        .valid_o    (valid_o),
        .settled_o  (settled_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int clamp_lg(input int sel);
        if (sel < 4) return 4;
        if (sel > 8) return 8;
        return sel;
    endfunction

    // three boxes of length M convolved: coefficient j counts (a,b,c) with a+b+c=j
    function automatic void build_coef(input int lg);
        int m = 1 << lg;
        for (int j = 0; j <= 3*m - 3; j++) begin
            longint acc = 0;
            for (int a = 0; a < m; a++) begin
                int lo = (j - a - m + 1 > 0) ? j - a - m + 1 : 0;
                int hi = (j - a < m - 1) ? j - a : m - 1;
                if (hi >= lo) acc += longint'(hi - lo + 1);
            end
            coef[j] = acc;
        end
    endfunction

    function automatic longint filt_sum();
        int m = 1 << m_lg;
        longint acc = 0;
        for (int j = 0; j <= 3*m - 3; j++) begin
            int idx = m_n - 1 - j;
            if (idx >= 0 && hist[idx % HIST]) acc += coef[j];
        end
        return acc;
    endfunction

    function automatic logic [15:0] scale_word(input longint raw, input int lg, input bit sgn);
        longint off = (raw << 15) >> (3 * lg);
        if (sgn) off = off - 16384;
        return off[15:0];
    endfunction

    task automatic check_outputs();
        vectors++;
        if (valid_o !== exp_valid) begin
            fails++;
            $display("FAIL %s valid_o: actual %0b expected %0b at %0t",
                     after_restart ? "R7" : "R6", valid_o, exp_valid, $time);
        end
        vectors++;
        if (settled_o !== exp_settled) begin
            fails++;
            $display("FAIL R8 settled_o: actual %0b expected %0b at %0t",
                     settled_o, exp_settled, $time);
        end
        vectors++;
        if (data_o !== exp_data) begin
            fails++;
            $display("FAIL %s data_o: actual %0d expected %0d at %0t",
                     exp_valid ? cur_tag : "R10", data_o, exp_data, $time);
        end
    endtask

    task automatic cycle(input bit en, input bit b, input int sel, input bit sgn);
        int eff;
        @(negedge clk);
        check_outputs();
        bit_en     = en;
        bit_in     = b;
        osr_log2   = sel[3:0];
        fmt_signed = sgn;
        eff = clamp_lg(sel);
        exp_valid = 1'b0;
        after_restart = 1'b0;
        if (eff != m_lg) begin
            m_lg = eff;
            build_coef(m_lg);
            m_n = 0;
            m_words = 0;
            exp_settled = 1'b0;
            after_restart = 1'b1;
        end else if (en) begin
            hist[m_n % HIST] = b;
            m_n++;
            if (m_n % (1 << m_lg) == 0) begin
                m_words++;
                exp_valid = 1'b1;
                exp_data = scale_word(filt_sum(), m_lg, sgn);
                if (m_words >= 3) exp_settled = 1'b1;
            end
        end
    endtask

    function automatic bit pick_bit(input int dens);
        if (dens < 0) begin
            alt_bit = ~alt_bit;
            return alt_bit;
        end
        return ($urandom_range(0, 99) < dens);
    endfunction

    // dens: percent of ones, -1 alternates; fmode: 0 offset, 1 signed, 2 random
    task automatic run_seg(input int sel, input int dens, input int en_pct,
                           input int nwords, input int fmode, input string tag);
        int target;
        int extra;
        cur_tag = tag;
        cycle(1'b0, 1'b0, sel, fmode == 1);
        target = m_words + nwords;
        while (m_words < target) begin
            bit e = ($urandom_range(0, 99) < en_pct);
            bit s = (fmode == 2) ? 1'($urandom_range(0, 1)) : (fmode == 1);
            cycle(e, e ? pick_bit(dens) : 1'b0, sel, s);
        end
        extra = $urandom_range(0, (1 << m_lg) - 1);
        for (int i = 0; i < extra; i++) begin
            cycle(1'b1, pick_bit(dens), sel, fmode == 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R2 watchdog expired before the run completed");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1205));
        build_coef(8);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values visible while reset is held
        vectors++;
        if (valid_o !== 1'b0 || settled_o !== 1'b0 || data_o !== 16'd0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual %0b/%0b/%0d expected 0/0/0",
                     valid_o, settled_o, data_o);
        end
        rst_n = 1'b1;

        // R2: random stream at the post-reset ratio 256
        run_seg(8, 50, 75, 4, 0, "R2");
        // R4: all ones at M = 16 reaches 32768 once settled
        run_seg(4, 100, 100, 5, 0, "R4");
        // R5: all zeros in signed format gives -16384
        run_seg(5, 0, 100, 4, 1, "R5");
        // R5: alternating bits sit at the signed midpoint
        run_seg(6, -1, 100, 4, 1, "R5");
        // R3: code 2 clamps to M = 16, then code 3 aliases and must not restart (R7)
        run_seg(2, 70, 60, 4, 2, "R3");
        run_seg(3, 70, 60, 3, 2, "R7");
        // R9: long run of ones at code 15 (M = 256) wraps the accumulators
        run_seg(15, 100, 100, 12, 0, "R9");
        // R7: code 8 aliases to the same ratio as 15
        run_seg(8, 30, 50, 3, 2, "R7");
        // R2: random ratios, densities and formats
        for (int s = 0; s < 8; s++) begin
            run_seg($urandom_range(0, 15), $urandom_range(0, 100),
                    $urandom_range(30, 100), $urandom_range(3, 5), 2, "R2");
        end
        @(negedge clk);
        check_outputs();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule